// File: doc/BRIEF.md
# Thermometer-to-Binary Output Encoder

This block is the digital back end of a parallel-comparator converter. A bank of comparators presents a (2^N − 1)-bit thermometer word, where each bit says whether the input lies above one reference tap. The encoder turns that word into an N-bit code in one clock cycle and registers the result. A valid strobe marks each new result, so the block can sit inside a pipeline.

A 2-bit select input picks the output format on every sample. The formats are straight binary, offset binary, two's complement and Gray code. Comparator outputs near the switching point can leave an isolated wrong bit, called a bubble. A three-input majority over neighbouring bits cleans the word before the search for the highest asserted bit.

An overrange flag is registered with each code and reports that the top of the scale was reached. N is a parameter with a default of 3, which gives a 7-bit thermometer word.

Top module: `therm_enc_top`

## Requirements
- R1: While `rst` is high at a rising edge, `codeOut`, `overRange` and `codeValid` are all 0 after that edge.
- R2: With `fmtSel` = 00 (straight binary), a well-formed word with the k lowest bits set (k = 0 … 2^N − 1) produces code k. All zeros gives 0 and all ones gives 2^N − 1.
- R3: A sample taken with `sampleEn` high appears on `codeOut` and `overRange` after the next rising edge. `codeValid` is high for exactly that one cycle per strobe.
- R4: While `sampleEn` is low, `codeOut` and `overRange` hold their values and `codeValid` is 0, whatever `thermIn` does.
- R5: With `fmtSel` = 01 (offset binary), the code equals the position code. The midpoint zone, with 2^(N−1) ones, gives 1 followed by zeros (100 for N = 3).
- R6: With `fmtSel` = 10 (two's complement), the code is the offset-binary code with its MSB inverted. For N = 3, the midpoint gives 000, all zeros gives 100 and all ones gives 011.
- R7: With `fmtSel` = 11 (Gray), the code is p XOR (p >> 1), where p is the position code. Codes for adjacent zones differ in exactly one bit.
- R8: Bubble suppression: cleaned bit i is the majority of raw bits i−1, i and i+1. A 1 is assumed below bit 0 and a 0 above the top bit. The position code is the index of the highest cleaned 1 plus one, or 0 if no cleaned bit is set. Examples for N = 3: 0000101 gives 2, 0001011 gives 3, 0100001 gives 1.
- R9: `overRange` is registered with the code. It is 1 exactly when the cleaned top bit is set, which means raw bits 2^N − 2 and 2^N − 3 are both 1.
- R10: `fmtSel` is sampled only on strobe cycles. Changing it with `sampleEn` low leaves `codeOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sampleEn | input | 1 | Sample strobe; captures the current word and format |
| thermIn | input | 2^N − 1 | Thermometer word from the comparator bank, bit 0 lowest tap |
| fmtSel | input | 2 | Output format: 00 straight, 01 offset, 10 two's complement, 11 Gray |
| codeOut | output | N | Registered output code |
| codeValid | output | 1 | High for one cycle after each strobe |
| overRange | output | 1 | Registered full-scale flag |

## Verification
Every well-formed thermometer level is swept through all four formats. This separates the format mappings from each other at the midpoint and at both ends of the scale, and it shows that adjacent Gray codes differ in one bit. Words with bubbles are chosen so that a plain highest-bit search and the majority-cleaned search give different codes, including an isolated high bit and a hole just below the boundary. Words that change between strobes, and a format select that changes between strobes, show the hold behaviour apart from the one-cycle strobe-to-valid latency. Words near the top of the scale separate the overrange rule from a simple test of the raw top bit.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

  typedef enum logic [1:0] {
    FMT_STRAIGHT = 2'b00,
    FMT_OFFSET   = 2'b01,
    FMT_TWOS     = 2'b10,
    FMT_GRAY     = 2'b11
  } fmt_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } ctrlStrobes_t;

endpackage

// File: rtl/therm_enc_ctrl.sv
module therm_enc_ctrl
  import therm_enc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sampleEn,
  output ctrlStrobes_t strobes,
  output logic         codeValid
);

  always_comb begin
    strobes.clear   = rst;
    strobes.capture = sampleEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) codeValid <= 1'b0;
    else     codeValid <= sampleEn;
  end

  // R3: a strobe yields valid on the next cycle
  a_r3_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> codeValid);
  // R4: no strobe, no valid
  a_r4_no_valid_without_strobe: assert property (@(posedge clk) disable iff (rst)
    !sampleEn |=> !codeValid);

endmodule

// File: rtl/therm_enc_datapath.sv
module therm_enc_datapath
  import therm_enc_pkg::*;
#(
  parameter int N = 3
) (
  input  logic             clk,
  input  ctrlStrobes_t     strobes,
  input  logic [(2**N)-2:0] thermIn,
  input  logic [1:0]       fmtSel,
  output logic [N-1:0]     codeOut,
  output logic             overRange
);

  localparam int M = (2**N) - 1;

  logic [M+1:0]  extWord;
  logic [M-1:0]  cleanWord;
  logic [N-1:0]  binCode;
  logic [N-1:0]  fmtCode;
  fmt_e          fmt;

  // Pad: 1 below bit 0, 0 above top bit
  assign extWord = {1'b0, thermIn, 1'b1};

  // Bubble suppression by three-input majority
  for (genvar g = 0; g < M; g++) begin : gMaj
    assign cleanWord[g] = (extWord[g]   & extWord[g+1]) |
                          (extWord[g]   & extWord[g+2]) |
                          (extWord[g+1] & extWord[g+2]);
  end

  // Highest cleaned bit search
  always_comb begin
    binCode = '0;
    for (int i = 0; i < M; i++) begin
      if (cleanWord[i]) binCode = N'(i + 1);
    end
  end

  // Output format selection
  always_comb begin
    fmt = fmt_e'(fmtSel);
    unique case (fmt)
      FMT_STRAIGHT: fmtCode = binCode;
      FMT_OFFSET:   fmtCode = binCode;
      FMT_TWOS:     fmtCode = {~binCode[N-1], binCode[N-2:0]};
      FMT_GRAY:     fmtCode = binCode ^ (binCode >> 1);
      default:      fmtCode = binCode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      codeOut   <= '0;
      overRange <= 1'b0;
    end else if (strobes.capture) begin
      codeOut   <= fmtCode;
      overRange <= cleanWord[M-1];
    end
  end

  // R1: reset clears the output register
  a_r1_clear_outputs: assert property (@(posedge clk)
    strobes.clear |=> (codeOut == '0 && !overRange));
  // R4: hold without strobe
  a_r4_hold_code: assert property (@(posedge clk) disable iff (strobes.clear)
    !strobes.capture |=> ($stable(codeOut) && $stable(overRange)));
  // R9: overrange agrees with full-scale search result
  a_r9_overrange_full_scale: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.capture |=> (overRange == ($past(binCode) == {N{1'b1}})));
  // R6: two's complement flips the position MSB
  a_r6_twos_msb: assert property (@(posedge clk) disable iff (strobes.clear)
    (strobes.capture && fmtSel == FMT_TWOS) |=> (codeOut[N-1] != $past(binCode[N-1])));

endmodule

// File: rtl/therm_enc_top.sv
module therm_enc_top
  import therm_enc_pkg::*;
#(
  parameter int N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleEn,
  input  logic [(2**N)-2:0] thermIn,
  input  logic [1:0]        fmtSel,
  output logic [N-1:0]      codeOut,
  output logic              codeValid,
  output logic              overRange
);

  ctrlStrobes_t strobes;

  therm_enc_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sampleEn  (sampleEn),
    .strobes   (strobes),
    .codeValid (codeValid)
  );

  therm_enc_datapath #(.N(N)) dp_i (
    .clk       (clk),
    .strobes   (strobes),
    .thermIn   (thermIn),
    .fmtSel    (fmtSel),
    .codeOut   (codeOut),
    .overRange (overRange)
  );

endmodule

// File: tb/therm_enc_top_tb_top.sv
`timescale 1ns/1ps
module therm_enc_top_tb_top;

  localparam int N = 3;
  localparam int M = (2**N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sampleEn = 1'b0;
  logic [M-1:0] thermIn = '0;
  logic [1:0]   fmtSel = 2'b00;
  logic [N-1:0] codeOut;
  logic         codeValid;
  logic         overRange;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  therm_enc_top #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .sampleEn(sampleEn), .thermIn(thermIn),
    .fmtSel(fmtSel), .codeOut(codeOut), .codeValid(codeValid), .overRange(overRange)
  );

  // Model from R8: majority cleaning then highest-bit search
  function automatic logic [N-1:0] posModel(input logic [M-1:0] t);
    logic [M+1:0] e;
    logic [N-1:0] p;
    e = {1'b0, t, 1'b1};
    p = '0;
    for (int i = 0; i < M; i++) begin
      if ((e[i] + e[i+1] + e[i+2]) >= 2) p = N'(i + 1);
    end
    return p;
  endfunction

  function automatic logic [N-1:0] fmtModel(input logic [N-1:0] p, input logic [1:0] f);
    case (f)
      2'b10:   return p ^ N'(1 << (N-1));
      2'b11:   return p ^ (p >> 1);
      default: return p;
    endcase
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  // Drive at negedge, capture at posedge, leave strobe low at following negedge
  task automatic sample(input logic [M-1:0] t, input logic [1:0] f);
    @(negedge clk);
    thermIn = t; fmtSel = f; sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 code", codeOut, 0);
    check("R1 valid", codeValid, 0);
    check("R1 overrange", overRange, 0);
    rst = 1'b0;
  endtask

  task automatic testFormatSweep(input logic [1:0] f, input string req);
    for (int k = 0; k <= M; k++) begin
      logic [M-1:0] t;
      t = M'((1 << k) - 1);
      sample(t, f);
      check(req, codeOut, fmtModel(N'(k), f));
      check("R3 valid", codeValid, 1);
    end
  endtask

  task automatic testStraight();
    testFormatSweep(2'b00, "R2");
    sample('0, 2'b00);
    check("R2 zero", codeOut, 0);
    sample('1, 2'b00);
    check("R2 full", codeOut, M);
  endtask

  task automatic testOffset();
    testFormatSweep(2'b01, "R5");
    sample(M'((1 << (2**(N-1))) - 1), 2'b01);
    check("R5 midpoint", codeOut, 1 << (N-1));
  endtask

  task automatic testTwos();
    testFormatSweep(2'b10, "R6");
    sample(M'((1 << (2**(N-1))) - 1), 2'b10);
    check("R6 midpoint", codeOut, 0);
    sample('0, 2'b10);
    check("R6 zero", codeOut, 4);
    sample('1, 2'b10);
    check("R6 full", codeOut, 3);
  endtask

  task automatic testGray();
    logic [N-1:0] prev;
    testFormatSweep(2'b11, "R7");
    sample('0, 2'b11);
    prev = codeOut;
    for (int k = 1; k <= M; k++) begin
      sample(M'((1 << k) - 1), 2'b11);
      check("R7 one-bit step", $countones(codeOut ^ prev), 1);
      prev = codeOut;
    end
  endtask

  task automatic testBubbles();
    sample(7'b0000101, 2'b00);
    check("R8 hole below", codeOut, 2);
    sample(7'b0001011, 2'b00);
    check("R8 hole at 2", codeOut, 3);
    sample(7'b0100001, 2'b00);
    check("R8 isolated high", codeOut, 1);
    sample(7'b1011111, 2'b00);
    check("R8 hole near top", codeOut, posModel(7'b1011111));
    for (int w = 0; w < (1 << M); w += 9) begin
      sample(M'(w), 2'b00);
      check("R8 pattern", codeOut, posModel(M'(w)));
    end
  endtask

  task automatic testOverrange();
    sample(7'b1111111, 2'b00);
    check("R9 full", overRange, 1);
    sample(7'b0111111, 2'b00);
    check("R9 below top", overRange, 0);
    sample(7'b1000000, 2'b00);
    check("R9 lone top bit", overRange, 0);
    sample(7'b1100000, 2'b11);
    check("R9 top pair", overRange, 1);
  endtask

  task automatic testHold();
    sample(7'b0000111, 2'b00);
    check("R3 code", codeOut, 3);
    @(negedge clk);
    check("R3 valid one cycle", codeValid, 0);
    thermIn = 7'b1111111; fmtSel = 2'b10;
    repeat (2) @(negedge clk);
    check("R4 hold code", codeOut, 3);
    check("R4 hold overrange", overRange, 0);
    check("R4 valid low", codeValid, 0);
    fmtSel = 2'b11;
    @(negedge clk);
    check("R10 format ignored", codeOut, 3);
  endtask

  initial begin
    testReset();
    testStraight();
    testOffset();
    testTwos();
    testGray();
    testBubbles();
    testOverrange();
    testHold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule